// File: doc/BRIEF.md
# Cascaded-Device SPI Frame Writer

This block is an SPI master for a string of identical 16-bit peripherals. The peripherals share one active-low select line and one serial clock. Serial data enters only the first peripheral, and each peripheral passes its overflow bits on to the next one. Together the peripherals behave as one long shift register of `NUM_DEV` × 16 bits. A rising edge on the select line makes every peripheral capture the word that currently sits in its own section of that register.

A client makes one request through a valid/ready handshake. The request carries a device position and a 16-bit word. The writer builds a full frame from it:

- The addressed position gets the word.
- Every other position gets an all-zero word, which the peripherals treat as "do nothing".

The writer then lowers the select line and sends the whole frame MSB first in SPI mode 0. It raises the select line to commit the frame, pulses `done`, and keeps the select line high for at least one serial-clock period before it accepts the next request. The serial clock is derived from the system clock. Each SCLK half period lasts `HALF_DIV` system cycles.

Top module: `cspi_chain_writer`

## Requirements
- R1: After reset, and whenever no frame is in progress, the outputs are `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0, `req_ready`=1 and `done`=0.
- R2: Each select-low window contains exactly `NUM_DEV`×16 rising SCLK edges, so the number of bits sent is always a whole number of 16-bit words.
- R3: The frame carries device position `NUM_DEV`-1 (farthest from the master) first and position 0 (nearest) last. Each word is sent MSB first. After the select line rises, the word sent first therefore sits in the farthest device.
- R4: The addressed position receives the request word, and every other position receives 16'h0000.
- R5: SPI mode 0: SCLK is low whenever select is high. MOSI changes only while SCLK is low and stays stable for the whole SCLK-high half period.
- R6: The select line falls on the cycle after a request is accepted, one half period before the first rising SCLK edge. It rises only while SCLK is low, one half period after the last falling SCLK edge.
- R7: `done` is high for exactly one cycle, and that cycle is the first cycle of select high after a frame.
- R8: Between two frames, the select line stays high for at least one SCLK period (2×`HALF_DIV` system cycles). `req_ready` stays low from acceptance until that gap has ended.
- R9: A request presented while the writer is busy is held off by `req_ready`=0. It is neither lost nor changed, and it is sent once `req_ready` returns.
- R10: Every SCLK half period, both high and low, lasts exactly `HALF_DIV` system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Writer can take a request this cycle |
| req_index | input | IDX_W | Target device position, 0 = nearest the master |
| req_word | input | WORD_W | Word for the target device |
| spi_cs_n | output | 1 | Shared active-low select; rising edge commits the frame |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data into the first device |
| done | output | 1 | One-cycle pulse when the frame is committed |

## Verification
The hardest case to reach from the ports is a request that arrives while a frame is still being shifted or while the inter-frame gap is still running. Only then can a dropped or corrupted request show up. The stimulus issues the next request on the cycle straight after the previous one is accepted and holds `req_valid` high through the whole busy period. A behavioural model then checks that the request is taken on the first ready cycle after the gap, and that its word lands in the correct device. A second bench-side model shifts the serial stream through `NUM_DEV` 16-bit registers, clocked on SCLK and committed on the select rise. This shows that the order of words and the zero fill give exactly one changed device.

// File: rtl/cspi_pkg.sv
package cspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/cspi_half_timer.sv
// Counts system cycles while a frame runs and flags the last cycle of each
// SCLK half period.
module cspi_half_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == CNT_LAST);

endmodule

// File: rtl/cspi_frame_build.sv
// Places the request word in the addressed slot and zero in every other slot.
// Slot s occupies bits [s*WORD_W +: WORD_W], so the top slot is sent first.
module cspi_frame_build #(
    parameter int NUM_DEV = 4,
    parameter int WORD_W  = 16,
    parameter int IDX_W   = 2
) (
    input  logic [IDX_W-1:0]          index,
    input  logic [WORD_W-1:0]         word,
    output logic [NUM_DEV*WORD_W-1:0] frame
);
    for (genvar s = 0; s < NUM_DEV; s++) begin : g_slot
        assign frame[s*WORD_W +: WORD_W] = (index == IDX_W'(s)) ? word : '0;
    end

endmodule

// File: rtl/cspi_frame_shifter.sv
// Parallel-load, MSB-first shift register that holds the frame in flight.
module cspi_frame_shifter #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               msb_out
);
    logic [FRAME_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = frame_in;
        end else if (shift) begin
            sr_d = {sr_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign msb_out = sr_q[FRAME_W-1];

endmodule

// File: rtl/cspi_chain_writer.sv
module cspi_chain_writer
    import cspi_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int WORD_W   = 16,
    parameter int HALF_DIV = 2,
    localparam int IDX_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [WORD_W-1:0] req_word,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              done
);
    localparam int FRAME_W = NUM_DEV * WORD_W;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [BIT_W-1:0] bits;
        logic             gap2;
        logic             cs_n;
        logic             sclk;
        logic             ready;
        logic             done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:    ST_IDLE,
        bits:  '0,
        gap2:  1'b0,
        cs_n:  1'b1,
        sclk:  1'b0,
        ready: 1'b1,
        done:  1'b0
    };

    seq_t               seq_d, seq_q;
    logic               tick;
    logic               run;
    logic               load;
    logic               shift;
    logic               msb;
    logic [FRAME_W-1:0] frame;

    assign run = (seq_q.st != ST_IDLE);

    cspi_half_timer #(
        .HALF_DIV (HALF_DIV)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    cspi_frame_build #(
        .NUM_DEV (NUM_DEV),
        .WORD_W  (WORD_W),
        .IDX_W   (IDX_W)
    ) u_build (
        .index (req_index),
        .word  (req_word),
        .frame (frame)
    );

    cspi_frame_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .frame_in (frame),
        .msb_out  (msb)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        load       = 1'b0;
        shift      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid && seq_q.ready) begin
                    seq_d.st    = ST_LOW;
                    seq_d.cs_n  = 1'b0;
                    seq_d.sclk  = 1'b0;
                    seq_d.ready = 1'b0;
                    seq_d.bits  = '0;
                    load        = 1'b1;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    seq_d.st   = ST_HIGH;
                    seq_d.sclk = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    seq_d.sclk = 1'b0;
                    if (seq_q.bits == BIT_LAST) begin
                        seq_d.st = ST_HOLD;
                    end else begin
                        seq_d.st   = ST_LOW;
                        seq_d.bits = seq_q.bits + 1'b1;
                        shift      = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    seq_d.st   = ST_GAP;
                    seq_d.cs_n = 1'b1;
                    seq_d.done = 1'b1;
                    seq_d.gap2 = 1'b0;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (seq_q.gap2) begin
                        seq_d.st    = ST_IDLE;
                        seq_d.ready = 1'b1;
                        seq_d.gap2  = 1'b0;
                    end else begin
                        seq_d.gap2 = 1'b1;
                    end
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = seq_q.ready;
    assign spi_cs_n  = seq_q.cs_n;
    assign spi_sclk  = seq_q.sclk;
    assign spi_mosi  = msb & ~seq_q.cs_n;
    assign done      = seq_q.done;

endmodule

// File: rtl/cspi_chain_writer_chk.sv
module cspi_chain_writer_chk #(
    parameter int NUM_DEV  = 4,
    parameter int WORD_W   = 16,
    parameter int HALF_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic done
);
    localparam int FRAME_W  = NUM_DEV * WORD_W;
    localparam int HIGH_MIN = 2 * HALF_DIV;

    logic sclk_prev;
    logic cs_prev;
    int   rise_cnt;
    int   high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
            rise_cnt  <= 0;
            high_cnt  <= HIGH_MIN;
        end else begin
            sclk_prev <= spi_sclk;
            cs_prev   <= spi_cs_n;
            if (!spi_cs_n && cs_prev) begin
                rise_cnt <= 0;
            end else if (spi_sclk && !sclk_prev) begin
                rise_cnt <= rise_cnt + 1;
            end
            if (!spi_cs_n) begin
                high_cnt <= 0;
            end else if (high_cnt < HIGH_MIN) begin
                high_cnt <= high_cnt + 1;
            end
        end
    end

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && !spi_sclk && !spi_mosi && !done));

    p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (rise_cnt == FRAME_W));

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    p_cs_before_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> !spi_cs_n);

    p_cs_rise_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (!spi_sclk && !$past(spi_sclk)));

    p_done_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cs_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

    p_gap_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (high_cnt >= HIGH_MIN));

    p_not_ready_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !req_ready);

    p_accept_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind cspi_chain_writer cspi_chain_writer_chk #(
    .NUM_DEV  (NUM_DEV),
    .WORD_W   (WORD_W),
    .HALF_DIV (HALF_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .done      (done)
);

// File: tb/cspi_chain_writer_bench.sv
module cspi_chain_writer_bench;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int H  = 2;
    localparam int B  = N * W;
    localparam int IW = 2;
    localparam int BUSY_CYC = 2 * B * H + 3 * H;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_index = '0;
    logic [W-1:0]  req_word = '0;
    logic          req_ready, spi_cs_n, spi_sclk, spi_mosi, done;

    always #5 clk = ~clk;

    cspi_chain_writer #(
        .NUM_DEV (N), .WORD_W (W), .HALF_DIV (H)
    ) u_cspi_chain_writer (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_index (req_index), .req_word (req_word), .spi_cs_n (spi_cs_n),
        .spi_sclk (spi_sclk), .spi_mosi (spi_mosi), .done (done)
    );

    int checks = 0;
    int errors = 0;
    int sent = 0;
    int committed = 0;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    // Behavioural reference: position in the busy window and the expected frame.
    bit           m_busy = 1'b0;
    int           m_j = 0;
    logic [B-1:0] m_frame = '0;
    int           q_idx[$];
    logic [W-1:0] q_word[$];

    function automatic logic [B-1:0] build(input int idx, input logic [W-1:0] wd);
        logic [B-1:0] f = '0;
        f[idx*W +: W] = wd;
        return f;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            m_j    = 0;
        end else if (!m_busy) begin
            if (req_valid) begin
                m_busy  = 1'b1;
                m_j     = 0;
                m_frame = build(int'(req_index), req_word);
                q_idx.push_back(int'(req_index));
                q_word.push_back(req_word);
            end
        end else if (m_j == BUSY_CYC - 1) begin
            m_busy = 1'b0;
        end else begin
            m_j++;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_cs, e_sclk, e_mosi, e_rdy, e_done;
            if (!m_busy) begin
                e_cs = 1; e_sclk = 0; e_mosi = 0; e_rdy = 1; e_done = 0;
            end else if (m_j < 2 * B * H) begin
                e_cs = 0; e_rdy = 0; e_done = 0;
                e_sclk = ((m_j % (2 * H)) >= H);
                e_mosi = m_frame[B - 1 - m_j / (2 * H)];
            end else if (m_j < 2 * B * H + H) begin
                e_cs = 0; e_sclk = 0; e_mosi = m_frame[0]; e_rdy = 0; e_done = 0;
            end else begin
                e_cs = 1; e_sclk = 0; e_mosi = 0; e_rdy = 0;
                e_done = (m_j == 2 * B * H + H);
            end
            check("R6 cs_n", 32'(spi_cs_n), 32'(e_cs));
            check("R10 sclk", 32'(spi_sclk), 32'(e_sclk));
            check("R3 R5 mosi", 32'(spi_mosi), 32'(e_mosi));
            check("R8 ready", 32'(req_ready), 32'(e_rdy));
            check("R7 done", 32'(done), 32'(e_done));
        end
    end

    // Model of the device string: shift on SCLK rise, commit on select rise.
    logic [W-1:0] sh [N] = '{default: '0};
    logic [W-1:0] lat[N] = '{default: '0};
    int           rises = 0;

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            for (int i = N - 1; i > 0; i--) sh[i] <= {sh[i][W-2:0], sh[i-1][W-1]};
            sh[0] <= {sh[0][W-2:0], spi_mosi};
            rises <= rises + 1;
        end
    end

    always @(negedge spi_cs_n) rises <= 0;

    always @(posedge spi_cs_n) begin
        for (int i = 0; i < N; i++) lat[i] <= sh[i];
    end

    always @(negedge clk) begin
        if (rst_n && done && q_idx.size() > 0) begin
            int           ti;
            logic [W-1:0] tw;
            ti = q_idx.pop_front();
            tw = q_word.pop_front();
            committed++;
            check("R2 bits per frame", 32'(rises), 32'(B));
            for (int i = 0; i < N; i++) begin
                if (i == ti) check($sformatf("R3 target dev%0d", i), 32'(lat[i]), 32'(tw));
                else         check($sformatf("R4 zero dev%0d", i), 32'(lat[i]), 32'h0);
            end
        end
    end

    task automatic send(input int idx, input logic [W-1:0] wd);
        logic r;
        @(posedge clk);
        #2;
        req_valid = 1'b1;
        req_index = IW'(idx);
        req_word  = wd;
        sent++;
        forever begin
            @(negedge clk);
            r = req_ready;
            @(posedge clk);
            if (r) break;
        end
        #2;
        req_valid = 1'b0;
        req_word  = '0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy || !req_ready);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset cs_n", 32'(spi_cs_n), 32'h1);
        check("R1 reset sclk", 32'(spi_sclk), 32'h0);
        check("R1 reset mosi", 32'(spi_mosi), 32'h0);
        check("R1 reset ready", 32'(req_ready), 32'h1);
        check("R1 reset done", 32'(done), 32'h0);

        send(2, 16'hA5C3);
        wait_idle();
        send(0, 16'h1234);          // nearest device, sent last
        send(3, 16'hFFFF);          // R9: presented while busy
        send(1, 16'h8001);
        wait_idle();
        send(3, 16'h0001);          // farthest device, sent first
        send(0, 16'h0000);
        send(1, 16'h7E5A);
        wait_idle();

        check("R9 every request committed", 32'(committed), 32'(sent));
        check("R1 idle cs_n after run", 32'(spi_cs_n), 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule